// File: doc/BRIEF.md
# Byte ALU with Full Flag Byte

This block is the arithmetic and logic slice that sits beside an 8-bit processor's register file. Each cycle it may be handed an accumulator byte, a second byte (the operand), the current flag byte and an operation code. It then produces a result byte, a complete new flag byte and a write strobe that tells the register file whether the result should be stored.

Three operations are covered. The first is exclusive-OR of the accumulator with the operand. The second is compare, which subtracts the operand from the accumulator to form flags only and never stores anything. The third is increment of the operand byte. All three compute every bit of the flag byte, including the two spare bits that mirror data bits. Increment leaves the carry bit exactly as it arrived.

The three operation units always run side by side. A register stage latches the selected unit's outputs, so a result appears one clock after its inputs are presented.

Top module: `alu8_flag_core`

## Requirements
- R1: While `rst` is high at a clock edge, `res_out` and `flags_out` become 0x00 and `res_we` becomes 0.
- R2: Outputs are registered. An operation presented with `op_vld` high at a clock edge shows its result on `res_out`, `flags_out` and `res_we` after that edge. The op codes on `op_sel` are 0 = exclusive-OR, 1 = compare and 2 = increment. `res_we` is 1 after exclusive-OR and after increment.
- R3: Exclusive-OR gives `res_out` = `acc_in` ^ `opnd_in`. In the flag byte, bit 7 is sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract and bit 0 carry. Sign is result bit 7. Zero is set when the result is 0x00. Parity is 1 when the result has an even number of ones. Half-carry, subtract and carry are cleared.
- R4: For exclusive-OR and increment, flag bits 5 and 3 equal result bits 5 and 3.
- R5: Compare sets `res_we` to 0 and leaves `res_out` unchanged. It sets subtract (bit 1) to 1. Sign and zero come from the 8-bit difference `acc_in` - `opnd_in`.
- R6: For compare, flag bits 5 and 3 equal bits 5 and 3 of `opnd_in`, not of the difference.
- R7: For compare, half-carry (bit 4) is 1 when the low nibble of `acc_in` is less than the low nibble of `opnd_in`. Carry (bit 0) is 1 when `acc_in` < `opnd_in`, both taken as unsigned.
- R8: For compare, overflow (bit 2) is 1 when the signed difference of the two bytes lies outside -128..127.
- R9: Increment gives `res_out` = `opnd_in` + 1, wrapping from 0xFF to 0x00. Overflow (bit 2) is 1 exactly when the result is 0x80. Half-carry is 1 exactly when the operand's low nibble was 0xF. Subtract is 0.
- R10: Increment copies carry (bit 0) from `flags_in` bit 0.
- R11: With `op_vld` low, or with `op_sel` = 3, a clock edge sets `res_we` to 0 and leaves `res_out` and `flags_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_vld | input | 1 | Operation present this cycle |
| op_sel | input | 2 | Operation code |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Operand byte |
| flags_in | input | 8 | Current flag byte |
| res_out | output | 8 | Registered result byte |
| flags_out | output | 8 | Registered flag byte |
| res_we | output | 1 | Result write strobe |

## Verification
Every result, flag bit and write strobe is due on the first clock edge after the inputs are presented. The bench changes the inputs on the falling edge and reads the outputs on the next falling edge, so each reading falls exactly one register stage after its stimulus. For compare and idle cycles, the bench also checks that the result byte still holds the value from the last operation that wrote it, which it tracks on its own side.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_XOR = 2'd0,
    OP_CMP = 2'd1,
    OP_INC = 2'd2,
    OP_RSV = 2'd3
  } alu_op_e;

  // flag byte, msb first: sign, zero, copy5, half, copy3, parity/overflow, subtract, carry
  typedef struct packed {
    logic sign;
    logic zero;
    logic cpy5;
    logic half;
    logic cpy3;
    logic pv;
    logic sub;
    logic carry;
  } flags_t;

endpackage

// File: rtl/alu8_xor_unit.sv
module alu8_xor_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] r;

  always_comb begin
    r            = a_i ^ b_i;
    res_o        = r;
    flg_o.sign   = r[MSB];
    flg_o.zero   = (r == '0);
    flg_o.cpy5   = r[5];
    flg_o.half   = 1'b0;
    flg_o.cpy3   = r[3];
    flg_o.pv     = ~(^r);
    flg_o.sub    = 1'b0;
    flg_o.carry  = 1'b0;
  end
endmodule

// File: rtl/alu8_cmp_unit.sv
module alu8_cmp_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output flags_t            flg_o
);
  localparam int MSB   = DATA_W - 1;
  localparam int NIB_W = 4;

  logic [DATA_W:0]  wide;
  logic [NIB_W:0]   low;
  logic [DATA_W-1:0] d;

  always_comb begin
    wide         = {1'b0, a_i} - {1'b0, b_i};
    low          = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]};
    d            = wide[DATA_W-1:0];
    flg_o.sign   = d[MSB];
    flg_o.zero   = (d == '0);
    flg_o.cpy5   = b_i[5];
    flg_o.half   = low[NIB_W];
    flg_o.cpy3   = b_i[3];
    flg_o.pv     = (a_i[MSB] ^ b_i[MSB]) & (d[MSB] ^ a_i[MSB]);
    flg_o.sub    = 1'b1;
    flg_o.carry  = wide[DATA_W];
  end
endmodule

// File: rtl/alu8_inc_unit.sv
module alu8_inc_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] r;

  always_comb begin
    r            = b_i + 1'b1;
    res_o        = r;
    flg_o.sign   = r[MSB];
    flg_o.zero   = (r == '0);
    flg_o.cpy5   = r[5];
    flg_o.half   = &b_i[3:0];
    flg_o.cpy3   = r[3];
    flg_o.pv     = (b_i == SMAX);
    flg_o.sub    = 1'b0;
    flg_o.carry  = cin_i;
  end
endmodule

// File: rtl/alu8_flag_core.sv
module alu8_flag_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_vld,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] res_out,
  output logic [7:0]        flags_out,
  output logic              res_we
);
  flags_t            x_flg, c_flg, i_flg, f_in;
  logic [DATA_W-1:0] x_res, i_res;
  alu_op_e           op;

  assign f_in = flags_t'(flags_in);
  assign op   = alu_op_e'(op_sel);

  alu8_xor_unit #(.DATA_W(DATA_W)) u_xor (
    .a_i(acc_in), .b_i(opnd_in), .res_o(x_res), .flg_o(x_flg)
  );

  alu8_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
    .a_i(acc_in), .b_i(opnd_in), .flg_o(c_flg)
  );

  alu8_inc_unit #(.DATA_W(DATA_W)) u_inc (
    .b_i(opnd_in), .cin_i(f_in.carry), .res_o(i_res), .flg_o(i_flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      flags_out <= '0;
      res_we    <= 1'b0;
    end else begin
      res_we <= 1'b0;
      if (op_vld) begin
        case (op)
          OP_XOR: begin
            res_out   <= x_res;
            flags_out <= x_flg;
            res_we    <= 1'b1;
          end
          OP_CMP: begin
            flags_out <= c_flg;
          end
          OP_INC: begin
            res_out   <= i_res;
            flags_out <= i_flg;
            res_we    <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/alu8_flag_core_chk.sv
module alu8_flag_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_vld,
  input logic [1:0] op_sel,
  input logic [7:0] acc_in,
  input logic [7:0] opnd_in,
  input logic [7:0] flags_in,
  input logic [7:0] res_out,
  input logic [7:0] flags_out,
  input logic       res_we
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_out == 8'h00 && flags_out == 8'h00 && !res_we));

  a_r3_xor_value: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_sel == 2'd0) |=>
      (res_we && res_out == $past(acc_in ^ opnd_in)
       && flags_out[4] == 1'b0 && flags_out[1] == 1'b0 && flags_out[0] == 1'b0));

  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_sel == 2'd1) |=> (!res_we && $stable(res_out) && flags_out[1]));

  a_r6_cmp_copy: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_sel == 2'd1) |=>
      (flags_out[5] == $past(opnd_in[5]) && flags_out[3] == $past(opnd_in[3])));

  a_r9_inc_value: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_sel == 2'd2) |=>
      (res_we && res_out == 8'($past(opnd_in) + 8'd1)
       && flags_out[2] == (res_out == 8'h80)));

  a_r10_inc_carry: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_sel == 2'd2) |=> (flags_out[0] == $past(flags_in[0])));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_vld || op_sel == 2'd3) |=>
      (!res_we && $stable(res_out) && $stable(flags_out)));
endmodule

bind alu8_flag_core alu8_flag_core_chk u_chk (.*);

// File: tb/alu8_flag_core_tb.sv
module alu8_flag_core_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_vld;
  logic [1:0] op_sel;
  logic [7:0] acc_in, opnd_in, flags_in;
  logic [7:0] res_out, flags_out;
  logic       res_we;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] held_res = 8'h00;
  logic [7:0] held_flg = 8'h00;

  always #5 clk = ~clk;

  alu8_flag_core u_dut (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .res_out(res_out), .flags_out(flags_out), .res_we(res_we)
  );

  // {op, acc, operand, flags in}
  localparam logic [25:0] VEC [12] = '{
    {2'd0, 8'h5A, 8'h0F, 8'h00},
    {2'd0, 8'h33, 8'h33, 8'hFF},
    {2'd0, 8'h80, 8'h01, 8'h01},
    {2'd1, 8'h50, 8'h20, 8'h00},
    {2'd1, 8'h20, 8'h50, 8'hFF},
    {2'd1, 8'h7F, 8'hFF, 8'h00},
    {2'd1, 8'hC3, 8'h3C, 8'h00},
    {2'd2, 8'h00, 8'h0F, 8'h00},
    {2'd2, 8'h00, 8'h27, 8'h01},
    {2'd2, 8'h00, 8'hA5, 8'h00},
    {2'd0, 8'h00, 8'h00, 8'h00},
    {2'd2, 8'hAA, 8'h7E, 8'hFE}
  };

  function automatic logic [8:0] model(input logic [1:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic [7:0] fin);
    logic [7:0] r, f;
    int sa, sb, sd;
    r = 8'h00; f = 8'h00;
    if (op == 2'd0) begin
      r = a ^ b;
      f = {r[7], r == 8'h00, r[5], 1'b0, r[3], ($countones(r) % 2) == 0, 1'b0, 1'b0};
    end else if (op == 2'd1) begin
      r  = 8'(int'(a) - int'(b));
      sa = (a >= 8'd128) ? int'(a) - 256 : int'(a);
      sb = (b >= 8'd128) ? int'(b) - 256 : int'(b);
      sd = sa - sb;
      f = {r[7], r == 8'h00, b[5], a[3:0] < b[3:0], b[3], (sd > 127) || (sd < -128),
           1'b1, a < b};
    end else begin
      r = 8'(int'(b) + 1);
      f = {r[7], r == 8'h00, r[5], b[3:0] == 4'hF, r[3], r == 8'h80, 1'b0, fin[0]};
    end
    return {f, op != 2'd1};
  endfunction

  task automatic check(input string req, input logic [7:0] got_r, input logic [7:0] exp_r,
                       input logic [7:0] got_f, input logic [7:0] exp_f,
                       input logic got_w, input logic exp_w);
    n_chk++;
    if (got_r !== exp_r || got_f !== exp_f || got_w !== exp_w) begin
      n_bad++;
      $display("FAIL %s: res=%h flags=%h we=%b expected res=%h flags=%h we=%b",
               req, got_r, got_f, got_w, exp_r, exp_f, exp_w);
    end
  endtask

  // drive at a falling edge, read at the next falling edge (one register stage)
  task automatic run(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] fin, input logic vld);
    op_vld = vld; op_sel = op; acc_in = a; opnd_in = b; flags_in = fin;
    @(negedge clk);
  endtask

  task automatic run_model(input string req, input logic [1:0] op, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] fin);
    logic [8:0] m;
    logic [7:0] er;
    m  = model(op, a, b, fin);
    run(op, a, b, fin, 1'b1);
    er = (op == 2'd1) ? held_res : ((op == 2'd0) ? (a ^ b) : 8'(b + 8'd1));
    check(req, res_out, er, flags_out, m[8:1], res_we, m[0]);
    held_res = er;
    held_flg = m[8:1];
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; op_vld = 1'b0; op_sel = 2'd0;
    acc_in = 8'h00; opnd_in = 8'h00; flags_in = 8'h00;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1", res_out, 8'h00, flags_out, 8'h00, res_we, 1'b0);
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: vector walk
    for (int i = 0; i < 12; i++)
      run_model("R2-vec", VEC[i][25:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

    // R3 R4: exclusive-OR corners
    run(2'd0, 8'hFF, 8'hFF, 8'h00, 1'b1);
    check("R3", res_out, 8'h00, flags_out, 8'h44, res_we, 1'b1);
    run(2'd0, 8'h28, 8'h00, 8'h00, 1'b1);
    check("R4", res_out, 8'h28, flags_out, 8'h2C, res_we, 1'b1);
    run(2'd0, 8'h01, 8'h00, 8'hFF, 1'b1);
    check("R3", res_out, 8'h01, flags_out, 8'h00, res_we, 1'b1);

    // R5 R6 R7 R8: compare corners; result byte stays 0x01
    run(2'd1, 8'h28, 8'h28, 8'h00, 1'b1);
    check("R6", res_out, 8'h01, flags_out, 8'h6A, res_we, 1'b0);
    run(2'd1, 8'h10, 8'h01, 8'h00, 1'b1);
    check("R7", res_out, 8'h01, flags_out, 8'h12, res_we, 1'b0);
    run(2'd1, 8'h80, 8'h01, 8'h00, 1'b1);
    check("R8", res_out, 8'h01, flags_out, 8'h16, res_we, 1'b0);
    run(2'd1, 8'h00, 8'h01, 8'h00, 1'b1);
    check("R5", res_out, 8'h01, flags_out, 8'h93, res_we, 1'b0);

    // R9 R10: increment corners
    run(2'd2, 8'h00, 8'h7F, 8'h01, 1'b1);
    check("R9", res_out, 8'h80, flags_out, 8'h95, res_we, 1'b1);
    run(2'd2, 8'h00, 8'hFF, 8'h00, 1'b1);
    check("R10", res_out, 8'h00, flags_out, 8'h50, res_we, 1'b1);

    // R11: idle and reserved code hold outputs
    run(2'd2, 8'h00, 8'h41, 8'h01, 1'b1);
    check("R9", res_out, 8'h42, flags_out, 8'h01, res_we, 1'b1);
    run(2'd0, 8'hF0, 8'h0F, 8'h00, 1'b0);
    check("R11", res_out, 8'h42, flags_out, 8'h01, res_we, 1'b0);
    run(2'd3, 8'hF0, 8'h0F, 8'hFF, 1'b1);
    check("R11", res_out, 8'h42, flags_out, 8'h01, res_we, 1'b0);

    // R1: reset again after activity
    rst = 1'b1;
    run(2'd0, 8'h12, 8'h34, 8'h00, 1'b1);
    check("R1", res_out, 8'h00, flags_out, 8'h00, res_we, 1'b0);
    rst = 1'b0; op_vld = 1'b0;

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule